// File: doc/BRIEF.md
# Programming-Port Frame Shifter

This block is the bit-level framing layer of a serial programming port. It runs on the fast external clock and divides it by sixteen into bit slots. In each slot it samples two input lanes together, a data lane and an instruction lane, and drives one bit onto a response lane. Every frame has eleven slots. The first slot carries a zero start bit, the next eight carry a payload byte with the most significant bit first, and the last two carry zero guard bits.

When a frame closes, the block checks its shape on both input lanes. A clean frame puts both payload bytes on parallel outputs and raises a one-cycle valid strobe. A frame that breaks the format raises a one-cycle error strobe instead, and the parallel outputs keep their earlier values. The command layer above may hand the block a byte to return to the host. That byte is shifted out, most significant bit first, during the first eight slots of the frame that follows. In every slot that carries no returned data, the response lane follows the ready level (1 = ready). Commands are decoded outside this block.

Top module: `prog_frame_shifter`

## Requirements
- R1: While reset is held and just after it is released, rx_valid_o and frame_err_o are 0, rx_data_o and rx_instr_o are 0x00, and resp_lane_o equals ready_i.
- R2: A bit slot lasts 16 clk cycles, counted from reset release. Each input lane is sampled only at the 8th rising clk edge of the slot. Lane levels in the other 15 cycles of the slot have no effect.
- R3: A frame is 11 slots, numbered 0 to 10. Slot 0 must be 0, slots 1..8 carry the payload with the MSB in slot 1, and slots 9 and 10 must be 0. Both lanes are captured in the same slots. When both lanes are well formed, rx_data_o and rx_instr_o take the payloads and rx_valid_o is high for the cycle right after the sampling edge of slot 10.
- R4: If either lane has a 1 in slot 0, 9 or 10, frame_err_o pulses in that same cycle instead, rx_valid_o stays 0, and rx_data_o and rx_instr_o keep their previous values.
- R5: A byte loaded with tx_load_i during frame k is driven on resp_lane_o in frame k+1. It appears MSB first in slots 0..7, one bit per slot, and resp_lane_o equals ready_i in slots 8..10. The level stays constant within a slot.
- R6: In a frame for which no byte was loaded, resp_lane_o equals ready_i in all 11 slots. A loaded byte is returned only once.
- R7: If several bytes are loaded during one frame, the last one is returned. A load in the final clk cycle of a frame still counts for the next frame.
- R8: Asserting rst_n low in the middle of a frame restarts slot and bit counting and drops any pending byte. The first frame after release is then received correctly, and no byte is returned in it.
- R9: rx_valid_o and frame_err_o are never high for two consecutive cycles and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast external clock |
| rst_n | input | 1 | synchronous reset, active low |
| data_lane_i | input | 1 | serial data input lane |
| instr_lane_i | input | 1 | serial instruction input lane |
| ready_i | input | 1 | ready level shown between data (1 = ready) |
| tx_byte_i | input | 8 | byte to return in the next frame |
| tx_load_i | input | 1 | loads tx_byte_i for the next frame |
| resp_lane_o | output | 1 | serial response lane |
| rx_data_o | output | 8 | payload of the last clean data-lane frame |
| rx_instr_o | output | 8 | payload of the last clean instruction-lane frame |
| rx_valid_o | output | 1 | one-cycle strobe for a clean frame |
| frame_err_o | output | 1 | one-cycle strobe for a malformed frame |

## Verification
Two functions can meet in the same clock cycle: the frame-boundary transfer of the pending return byte into the output shifter, and a new tx_load_i. The bench raises tx_load_i in exactly the last cycle of slot 10, so the load and the transfer share one edge. It then checks that the byte appears in the next frame and is not lost or held back a further frame. A second case puts two loads into one frame and expects the later byte on the lane. In a third, the lanes are driven to the wrong value in every cycle of the slot except the sampling cycle, which pins down the sample point.

// File: rtl/pfs_pkg.sv
// Shared constants for the programming-port frame shifter.
// Assumes: input lanes are indexed by the enum below.
package pfs_pkg;
    localparam int IN_LANES = 2;

    typedef enum int {
        LANE_DATA  = 0,
        LANE_INSTR = 1
    } lane_idx_e;
endpackage

// File: rtl/pfs_slot_timer.sv
// Divides the external clock into bit slots and counts slots within a frame.
// Assumes: DIV is a power of two and SAMPLE_AT < DIV. Reset is synchronous, active low.
module pfs_slot_timer #(
    parameter int DIV        = 16,
    parameter int SAMPLE_AT  = 7,
    parameter int FRAME_BITS = 11,
    localparam int CW = $clog2(DIV),
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          sample_o,
    output logic          slot_end_o,
    output logic          last_bit_o,
    output logic [BW-1:0] bitpos_o
);
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] pos_q;

    // Advance the in-slot counter each cycle and the slot index at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pos_q <= '0;
        end else begin
            cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            if (cnt_q == CW'(DIV - 1))
                pos_q <= (pos_q == BW'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
        end
    end

    assign sample_o   = (cnt_q == CW'(SAMPLE_AT));
    assign slot_end_o = (cnt_q == CW'(DIV - 1));
    assign last_bit_o = (pos_q == BW'(FRAME_BITS - 1));
    assign bitpos_o   = pos_q;
endmodule

// File: rtl/pfs_lane_capture.sv
// Shifts one input lane at each sample tick and presents the full frame,
// including the bit being sampled in this cycle.
// Assumes: sample_i is high for one cycle per slot.
module pfs_lane_capture #(
    parameter int FRAME_BITS = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_i,
    input  logic                  lane_i,
    output logic [FRAME_BITS-1:0] frame_o
);
    logic [FRAME_BITS-2:0] sh_q;

    // Collect earlier bits of the frame, oldest in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (sample_i)
            sh_q <= {sh_q[FRAME_BITS-3:0], lane_i};
    end

    assign frame_o = {sh_q, lane_i};
endmodule

// File: rtl/pfs_return_lane.sv
// Holds a byte for the next frame and shifts it MSB first onto the response
// lane. Outside returned data the lane shows the ready level.
// Assumes: frame boundary = slot_end_i and last_bit_i in the same cycle.
module pfs_return_lane #(
    parameter int PAY_BITS = 8,
    parameter int BW       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_end_i,
    input  logic                last_bit_i,
    input  logic [BW-1:0]       bitpos_i,
    input  logic                ready_i,
    input  logic [PAY_BITS-1:0] tx_byte_i,
    input  logic                tx_load_i,
    output logic                lane_o
);
    logic [PAY_BITS-1:0] pend_q;
    logic                pend_v_q;
    logic [PAY_BITS-1:0] word_q;
    logic                rd_frame_q;
    logic                boundary;

    assign boundary = slot_end_i && last_bit_i;

    // Move the pending (or same-cycle) byte into the shifter at a frame boundary,
    // shift at every other slot end, and keep the latest load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_v_q   <= 1'b0;
            word_q     <= '0;
            rd_frame_q <= 1'b0;
        end else if (boundary) begin
            word_q     <= tx_load_i ? tx_byte_i : (pend_v_q ? pend_q : '0);
            rd_frame_q <= tx_load_i || pend_v_q;
            pend_q     <= '0;
            pend_v_q   <= 1'b0;
        end else begin
            if (slot_end_i)
                word_q <= {word_q[PAY_BITS-2:0], 1'b0};
            if (tx_load_i) begin
                pend_q   <= tx_byte_i;
                pend_v_q <= 1'b1;
            end
        end
    end

    assign lane_o = (rd_frame_q && (bitpos_i < BW'(PAY_BITS))) ? word_q[PAY_BITS-1] : ready_i;
endmodule

// File: rtl/prog_frame_shifter.sv
// Top of the programming-port frame shifter: two input lanes captured in
// lockstep, format checked at frame end, one response lane driven.
// Assumes: all ports synchronous to clk, rst_n synchronous active low.
module prog_frame_shifter
    import pfs_pkg::*;
#(
    parameter int PAY_BITS   = 8,
    parameter int TRAIL_BITS = 2,
    parameter int DIV        = 16,
    parameter int SAMPLE_AT  = 7,
    localparam int FB = 1 + PAY_BITS + TRAIL_BITS,
    localparam int BW = $clog2(FB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_lane_i,
    input  logic                instr_lane_i,
    input  logic                ready_i,
    input  logic [PAY_BITS-1:0] tx_byte_i,
    input  logic                tx_load_i,
    output logic                resp_lane_o,
    output logic [PAY_BITS-1:0] rx_data_o,
    output logic [PAY_BITS-1:0] rx_instr_o,
    output logic                rx_valid_o,
    output logic                frame_err_o
);
    logic          sample, slot_end, last_bit;
    logic [BW-1:0] bitpos;
    logic [IN_LANES-1:0] lane_in;
    logic [IN_LANES-1:0] lane_ok;
    logic [FB-1:0]       lane_frm [IN_LANES];
    logic                frame_done;

    assign lane_in[LANE_DATA]  = data_lane_i;
    assign lane_in[LANE_INSTR] = instr_lane_i;

    pfs_slot_timer #(.DIV(DIV), .SAMPLE_AT(SAMPLE_AT), .FRAME_BITS(FB)) u_timer (
        .clk(clk), .rst_n(rst_n), .sample_o(sample), .slot_end_o(slot_end),
        .last_bit_o(last_bit), .bitpos_o(bitpos)
    );

    for (genvar g = 0; g < IN_LANES; g++) begin : g_lane
        pfs_lane_capture #(.FRAME_BITS(FB)) u_cap (
            .clk(clk), .rst_n(rst_n), .sample_i(sample),
            .lane_i(lane_in[g]), .frame_o(lane_frm[g])
        );
        assign lane_ok[g] = !lane_frm[g][FB-1] && (lane_frm[g][TRAIL_BITS-1:0] == '0);
    end

    assign frame_done = sample && last_bit;

    // Publish clean frames with a valid strobe, flag malformed ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_o   <= '0;
            rx_instr_o  <= '0;
            rx_valid_o  <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            rx_valid_o  <= 1'b0;
            frame_err_o <= 1'b0;
            if (frame_done) begin
                if (&lane_ok) begin
                    rx_data_o  <= lane_frm[LANE_DATA][FB-2 -: PAY_BITS];
                    rx_instr_o <= lane_frm[LANE_INSTR][FB-2 -: PAY_BITS];
                    rx_valid_o <= 1'b1;
                end else begin
                    frame_err_o <= 1'b1;
                end
            end
        end
    end

    pfs_return_lane #(.PAY_BITS(PAY_BITS), .BW(BW)) u_ret (
        .clk(clk), .rst_n(rst_n), .slot_end_i(slot_end), .last_bit_i(last_bit),
        .bitpos_i(bitpos), .ready_i(ready_i), .tx_byte_i(tx_byte_i),
        .tx_load_i(tx_load_i), .lane_o(resp_lane_o)
    );
endmodule

// File: rtl/pfs_checker.sv
// Port-level properties of the frame shifter. Keeps its own count of cycles
// since reset to locate slot phases.
// Assumes: bound to prog_frame_shifter with matching parameters.
module pfs_checker #(
    parameter int PAY_BITS   = 8,
    parameter int DIV        = 16,
    parameter int SAMPLE_AT  = 7,
    parameter int FB         = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ready_i,
    input logic                resp_lane_o,
    input logic [PAY_BITS-1:0] rx_data_o,
    input logic [PAY_BITS-1:0] rx_instr_o,
    input logic                rx_valid_o,
    input logic                frame_err_o
);
    localparam int CW = $clog2(DIV);
    localparam int BW = $clog2(FB);
    logic [CW-1:0] ph_q;
    logic [BW-1:0] slot_q;
    logic          armed_q;

    // Track phase and slot from reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= '0;
            slot_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            ph_q    <= ph_q + 1'b1;
            if (ph_q == CW'(DIV - 1))
                slot_q <= (slot_q == BW'(FB - 1)) ? '0 : slot_q + 1'b1;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o || frame_err_o) |=> !(rx_valid_o || frame_err_o)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid_o && frame_err_o)); // R9
    AST_STROBE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o || frame_err_o) |-> (ph_q == CW'(SAMPLE_AT + 1) && slot_q == BW'(FB - 1))); // R3
    AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !rx_valid_o) |-> ($stable(rx_data_o) && $stable(rx_instr_o))); // R4
    AST_LANE_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ph_q != '0 && $stable(ready_i)) |-> $stable(resp_lane_o)); // R5
endmodule

bind prog_frame_shifter pfs_checker #(
    .PAY_BITS(PAY_BITS), .DIV(DIV), .SAMPLE_AT(SAMPLE_AT), .FB(FB)
) u_pfs_chk (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .resp_lane_o(resp_lane_o),
    .rx_data_o(rx_data_o), .rx_instr_o(rx_instr_o),
    .rx_valid_o(rx_valid_o), .frame_err_o(frame_err_o)
);

// File: tb/prog_frame_shifter_tb.sv
module prog_frame_shifter_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 10;

    function automatic logic [10:0] fr(input logic [7:0] p, input logic s, input logic [1:0] t);
        return {s, p, t};
    endfunction

    // {din11, ins11, l1_slot4, l1_cyc4, l1_byte8, l2_slot4, l2_byte8, ready1, err1}; slot 15 = none
    localparam logic [51:0] VECS [NV] = '{
        {fr(8'hA5,0,0), fr(8'h3C,0,0), 4'd4,  4'd5,  8'hC3, 4'd15, 8'h00, 1'b1, 1'b0},
        {fr(8'h00,0,0), fr(8'hFF,0,0), 4'd15, 4'd0,  8'h00, 4'd15, 8'h00, 1'b1, 1'b0},
        {fr(8'h5A,1,0), fr(8'h11,0,0), 4'd2,  4'd5,  8'h96, 4'd15, 8'h00, 1'b1, 1'b1},
        {fr(8'h81,0,0), fr(8'h7E,0,0), 4'd15, 4'd0,  8'h00, 4'd15, 8'h00, 1'b0, 1'b0},
        {fr(8'h34,0,0), fr(8'h12,0,1), 4'd15, 4'd0,  8'h00, 4'd15, 8'h00, 1'b0, 1'b1},
        {fr(8'hFF,0,2), fr(8'h00,0,0), 4'd15, 4'd0,  8'h00, 4'd15, 8'h00, 1'b1, 1'b1},
        {fr(8'hFF,0,0), fr(8'h01,0,0), 4'd10, 4'd14, 8'h5E, 4'd15, 8'h00, 1'b1, 1'b0},
        {fr(8'h0F,0,0), fr(8'hF0,0,0), 4'd1,  4'd5,  8'h11, 4'd6,  8'h22, 1'b1, 1'b0},
        {fr(8'hC6,0,0), fr(8'h6C,0,0), 4'd15, 4'd0,  8'h00, 4'd15, 8'h00, 1'b0, 1'b0},
        {fr(8'h01,0,0), fr(8'h80,0,0), 4'd15, 4'd0,  8'h00, 4'd15, 8'h00, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic data_lane = 1'b0, instr_lane = 1'b0, ready = 1'b1, tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic resp_lane, rx_valid, frame_err;
    logic [7:0] rx_data, rx_instr;

    int checks = 0, errors = 0;
    logic       cur_has = 1'b0, nxt_has;
    logic [7:0] cur_byte = 8'h00, nxt_byte, exp_data = 8'h00, exp_instr = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prog_frame_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .data_lane_i(data_lane), .instr_lane_i(instr_lane),
        .ready_i(ready), .tx_byte_i(tx_byte), .tx_load_i(tx_load), .resp_lane_o(resp_lane),
        .rx_data_o(rx_data), .rx_instr_o(rx_instr), .rx_valid_o(rx_valid), .frame_err_o(frame_err)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one frame starting at a slot boundary (called at the negedge before slot 0).
    task automatic run_frame(input logic [10:0] d, input logic [10:0] i, input int l1s, input int l1c,
                             input logic [7:0] l1b, input int l2s, input logic [7:0] l2b,
                             input logic rdy, input logic narrow, input logic experr);
        logic [10:0] got, exp_lane;
        ready = rdy;
        nxt_has = 1'b0;
        nxt_byte = 8'h00;
        for (int s = 0; s < 11; s++)
            exp_lane[10-s] = (cur_has && s < 8) ? cur_byte[7-s] : rdy;
        for (int b = 0; b < 11; b++) begin
            data_lane  = narrow ? ~d[10-b] : d[10-b];
            instr_lane = narrow ? ~i[10-b] : i[10-b];
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                tx_load = 1'b0;
                if (narrow && c < 15) begin
                    data_lane  = (c + 1 == 7) ? d[10-b] : ~d[10-b];
                    instr_lane = (c + 1 == 7) ? i[10-b] : ~i[10-b];
                end
                if (b == l1s && c == l1c) begin
                    tx_load = 1'b1; tx_byte = l1b; nxt_has = 1'b1; nxt_byte = l1b;
                end
                if (b == l2s && c == 5) begin
                    tx_load = 1'b1; tx_byte = l2b; nxt_has = 1'b1; nxt_byte = l2b;
                end
                if (c == 3) got[10-b] = resp_lane;
                if (b == 10 && c == 7) begin
                    if (!experr) begin
                        exp_data = d[9:2];
                        exp_instr = i[9:2];
                    end
                    check(rx_valid == !experr, "R3 valid strobe", rx_valid, !experr);
                    check(frame_err == experr, "R4 error strobe", frame_err, experr);
                    check(rx_data == exp_data, "R3/R4 data payload", rx_data, exp_data);
                    check(rx_instr == exp_instr, "R3/R4 instr payload", rx_instr, exp_instr);
                end
                if (b == 10 && c == 8)
                    check(!rx_valid && !frame_err, "R9 strobe width", {rx_valid, frame_err}, 0);
            end
        end
        check(got == exp_lane, "R5/R6/R7 response lane", got, exp_lane);
        cur_has = nxt_has;
        cur_byte = nxt_byte;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!rx_valid && !frame_err && rx_data == 0 && rx_instr == 0, "R1 reset outputs",
              {rx_valid, frame_err, rx_data, rx_instr}, 0);
        check(resp_lane == ready, "R1 lane shows ready", resp_lane, ready);
        rst_n = 1'b1;
        check(!rx_valid && rx_data == 0 && resp_lane == 1'b1, "R1 after release",
              {rx_valid, rx_data, resp_lane}, 1);

        for (int v = 0; v < NV; v++)
            run_frame(VECS[v][51:41], VECS[v][40:30], int'(VECS[v][29:26]), int'(VECS[v][25:22]),
                      VECS[v][21:14], int'(VECS[v][13:10]), VECS[v][9:2], VECS[v][1], 1'b0, VECS[v][0]);

        // R2: lanes correct only in the sampling cycle of each slot
        run_frame(fr(8'hB4,0,0), fr(8'h2D,0,0), 15, 0, 8'h00, 15, 8'h00, 1'b1, 1'b1, 1'b0);

        // R8: reset in the middle of a frame, with a byte pending
        data_lane = 1'b1; instr_lane = 1'b1;
        repeat (20) @(negedge clk);
        tx_load = 1'b1; tx_byte = 8'h77;
        @(negedge clk);
        tx_load = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rx_data == 0 && !rx_valid && resp_lane == ready, "R8 state after mid-frame reset",
              {rx_data, rx_valid, resp_lane}, {8'h00, 1'b0, ready});
        cur_has = 1'b0;
        exp_data = 8'h00;
        exp_instr = 8'h00;
        run_frame(fr(8'hE7,0,0), fr(8'h19,0,0), 15, 0, 8'h00, 15, 8'h00, 1'b0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule